// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a small 8-bit controller goes to sleep, which clocks stay alive while it sleeps, and when it comes back. Software writes a two-bit sleep-kind field inside an 8-bit clock configuration byte. The CPU then issues a one-cycle stop strobe. The sequencer answers by gating the CPU clock and switching off the clocks that the chosen sleep kind does not need. If an interrupt request is already pending when the strobe arrives, the strobe has no effect and the CPU keeps running.

The sequencer itself runs on an always-on control clock. It samples every wake input on that clock. A wake from an external interrupt or from the sleep kind's own timer event does not restart the CPU at once. The main oscillator comes on first, and a stabilization counter runs for `STAB_CYCLES` cycles. After that, a single-cycle resume pulse tells the core to continue at the instruction after the stop. An asynchronous reset ends any sleep at once.

The controller has four states. `ST_RUN` is the awake state. It moves to `ST_SLEEP` on a stop strobe when no interrupt is pending. `ST_SLEEP` moves to `ST_STAB` on an accepted wake event. `ST_STAB` moves to `ST_RESUME` when the counter expires. `ST_RESUME` lasts one cycle and then returns to `ST_RUN`. Reset from any state returns to `ST_RUN`.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the outputs take their awake values. These are main_osc_en=1, rc_osc_en=1, presc_en=1, presc_slow=0, tmr0_en=1, cpu_clk_en=1 and resume_pulse=0. The configuration byte cfg_q reads 0x00.
- R2: cfg_q loads cfg_wdata only when cfg_we=1 and cfg_bitop=0. A write with cfg_bitop=1 leaves cfg_q unchanged. The sleep kind is taken from cfg_q bits [6:5].
- R3: Kind 00 is full stop. In sleep it turns off main_osc_en, rc_osc_en, presc_en and tmr0_en, and holds presc_slow=0.
- R4: Kind 01 is RC-watchdog sleep. In sleep it keeps rc_osc_en=1 and drives main_osc_en, presc_en, tmr0_en and presc_slow to 0.
- R5: Kinds 10 and 11 are timer sleep. The low bit is ignored. In sleep it keeps main_osc_en=1, presc_en=1 and tmr0_en=1, forces presc_slow=1 (the divide-by-2048 setting only), and drives rc_osc_en=0.
- R6: cpu_clk_en is 0 for every cycle in which the block is asleep or stabilizing.
- R7: If any bit of irq_hi or irq_lo is set when stop_req is high, the block stays awake and all outputs keep their awake values.
- R8: A high bit on ext_int (INT0 or INT1) wakes the block from any sleep kind.
- R9: tmr0_evt wakes the block only in timer sleep. wdt_evt wakes it only in RC-watchdog sleep. In any other sleep kind these events leave the block asleep with its outputs unchanged.
- R10: The wake input is sampled on one edge. From that edge, cpu_clk_en stays 0 for exactly STAB_CYCLES cycles. During those cycles main_osc_en, rc_osc_en, presc_en and tmr0_en are 1 and presc_slow is 0. Next comes one cycle with resume_pulse=1 and cpu_clk_en=1, and after that the awake values.
- R11: An asynchronous reset during sleep returns the block at once to the awake values and clears the sleep-kind field to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bitop | input | 1 | Marks the write as a bit set/clear access, which is ignored |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_q | output | 8 | Current configuration byte |
| irq_hi | input | 8 | Pending flags, high interrupt group |
| irq_lo | input | 8 | Pending flags, low interrupt group |
| stop_req | input | 1 | One-cycle sleep request from the CPU |
| ext_int | input | 2 | External interrupt wake inputs (INT0, INT1) |
| tmr0_evt | input | 1 | Timer0 wake event |
| wdt_evt | input | 1 | Watchdog wake event |
| main_osc_en | output | 1 | Main oscillator enable |
| rc_osc_en | output | 1 | Internal RC oscillator enable |
| presc_en | output | 1 | Prescaler enable |
| presc_slow | output | 1 | Force the prescaler to the divide-by-2048 setting |
| tmr0_en | output | 1 | Timer0 clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| resume_pulse | output | 1 | One-cycle pulse that resumes the CPU |

## Verification
The hardest cases are wake events that arrive in the wrong sleep kind. A timer event during RC-watchdog sleep, or a watchdog event during full stop, must change nothing. The stimulus reaches these cases by programming each kind through a whole-byte write, entering sleep, and then pulsing the foreign event. The outputs are checked on the cycle after the pulse, before the real wake source is applied. The stabilization window is checked cycle by cycle, so the monitor catches an off-by-one in the counter. The bench also enters sleep and then pulls reset low, to show that the asynchronous path clears the sleep-kind field.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_STAB   = 2'd2,
        ST_RESUME = 2'd3
    } lpm_state_e;

    typedef enum logic [1:0] {
        SLP_FULL_STOP = 2'd0,
        SLP_RC_WDT    = 2'd1,
        SLP_WAKE_TMR  = 2'd2
    } sleep_kind_e;

    typedef struct packed {
        logic main_osc;
        logic rc_osc;
        logic presc;
        logic presc_slow;
        logic tmr0;
    } clk_set_t;

    localparam clk_set_t CLKS_AWAKE = '{main_osc: 1'b1, rc_osc: 1'b1, presc: 1'b1,
                                        presc_slow: 1'b0, tmr0: 1'b1};

endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bitop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    logic byte_write;

    assign byte_write = wr_en && !wr_bitop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (byte_write) begin
            q <= wdata;
        end
    end

    AST_BITOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bitop) |=> $stable(q)); // R2

endmodule

// File: rtl/lpm_mode_decode.sv
module lpm_mode_decode
    import lpm_pkg::*;
#(
    parameter int FIELD_W = 2
) (
    input  logic [FIELD_W-1:0] field,
    output sleep_kind_e        kind,
    output clk_set_t           sleep_clks,
    output logic               tmr_wake_ok,
    output logic               wdt_wake_ok
);

    logic [1:0] sel;

    generate
        if (FIELD_W >= 2) begin : g_wide
            assign sel = field[1:0];
        end else begin : g_narrow
            assign sel = {1'b0, field[0]};
        end
    endgenerate

    always_comb begin
        unique casez (sel)
            2'b00:   kind = SLP_FULL_STOP;
            2'b01:   kind = SLP_RC_WDT;
            default: kind = SLP_WAKE_TMR;
        endcase
    end

    always_comb begin
        sleep_clks  = '0;
        tmr_wake_ok = 1'b0;
        wdt_wake_ok = 1'b0;
        unique case (kind)
            SLP_FULL_STOP: begin
                sleep_clks = '0;
            end
            SLP_RC_WDT: begin
                sleep_clks.rc_osc = 1'b1;
                wdt_wake_ok       = 1'b1;
            end
            SLP_WAKE_TMR: begin
                sleep_clks.main_osc   = 1'b1;
                sleep_clks.presc      = 1'b1;
                sleep_clks.presc_slow = 1'b1;
                sleep_clks.tmr0       = 1'b1;
                tmr_wake_ok           = 1'b1;
            end
            default: begin
                sleep_clks = '0;
            end
        endcase
    end

endmodule

// File: rtl/lpm_stab_timer.sv
module lpm_stab_timer #(
    parameter int CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic active,
    output logic done
);

    localparam int SPAN  = (CYCLES > 1) ? CYCLES : 2;
    localparam int CNT_W = $clog2(SPAN);

    generate
        if (CYCLES <= 1) begin : g_bypass
            assign done = active;
        end else begin : g_count
            logic [CNT_W-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (load) begin
                    cnt <= CNT_W'(CYCLES - 1);
                end else if (active && cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end
            end

            assign done = active && (cnt == '0);

            AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
                (active && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R10
        end
    endgenerate

endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
    import lpm_pkg::*;
#(
    parameter int CFG_W       = 8,
    parameter int MODE_LSB    = 5,
    parameter int IRQ_W       = 8,
    parameter int N_EXT_INT   = 2,
    parameter int STAB_CYCLES = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_bitop,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_q,
    input  logic [IRQ_W-1:0]     irq_hi,
    input  logic [IRQ_W-1:0]     irq_lo,
    input  logic                 stop_req,
    input  logic [N_EXT_INT-1:0] ext_int,
    input  logic                 tmr0_evt,
    input  logic                 wdt_evt,
    output logic                 main_osc_en,
    output logic                 rc_osc_en,
    output logic                 presc_en,
    output logic                 presc_slow,
    output logic                 tmr0_en,
    output logic                 cpu_clk_en,
    output logic                 resume_pulse
);

    localparam int MODE_W = 2;

    lpm_state_e  state, state_nx;
    sleep_kind_e kind;
    clk_set_t    sleep_clks, clks;
    logic        tmr_wake_ok, wdt_wake_ok;
    logic        irq_any, wake_hit, stab_load, stab_active, stab_done;

    lpm_cfg_reg #(.DATA_W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_bitop (cfg_bitop),
        .wdata    (cfg_wdata),
        .q        (cfg_q)
    );

    lpm_mode_decode #(.FIELD_W(MODE_W)) u_dec (
        .field       (cfg_q[MODE_LSB +: MODE_W]),
        .kind        (kind),
        .sleep_clks  (sleep_clks),
        .tmr_wake_ok (tmr_wake_ok),
        .wdt_wake_ok (wdt_wake_ok)
    );

    assign irq_any  = (|irq_hi) || (|irq_lo);
    assign wake_hit = (|ext_int) || (tmr0_evt && tmr_wake_ok) || (wdt_evt && wdt_wake_ok);

    assign stab_load   = (state == ST_SLEEP) && wake_hit;
    assign stab_active = (state == ST_STAB);

    lpm_stab_timer #(.CYCLES(STAB_CYCLES)) u_stab (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (stab_load),
        .active (stab_active),
        .done   (stab_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    if (stop_req && !irq_any) state_nx = ST_SLEEP;
            ST_SLEEP:  if (wake_hit)             state_nx = ST_STAB;
            ST_STAB:   if (stab_done)            state_nx = ST_RESUME;
            ST_RESUME:                           state_nx = ST_RUN;
            default:                             state_nx = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        clks         = CLKS_AWAKE;
        cpu_clk_en   = 1'b1;
        resume_pulse = 1'b0;
        unique case (state)
            ST_RUN: begin
                clks       = CLKS_AWAKE;
                cpu_clk_en = 1'b1;
            end
            ST_SLEEP: begin
                clks       = sleep_clks;
                cpu_clk_en = 1'b0;
            end
            ST_STAB: begin
                clks       = CLKS_AWAKE;
                cpu_clk_en = 1'b0;
            end
            ST_RESUME: begin
                clks         = CLKS_AWAKE;
                cpu_clk_en   = 1'b1;
                resume_pulse = 1'b1;
            end
            default: begin
                clks       = CLKS_AWAKE;
                cpu_clk_en = 1'b1;
            end
        endcase
    end

    assign main_osc_en = clks.main_osc;
    assign rc_osc_en   = clks.rc_osc;
    assign presc_en    = clks.presc;
    assign presc_slow  = clks.presc_slow;
    assign tmr0_en     = clks.tmr0;

    AST_PENDING_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_req && irq_any) |=> cpu_clk_en); // R7

    AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse); // R10

    AST_RESUME_AFTER_STAB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_pulse) |-> $past(stab_active)); // R10

    AST_FOREIGN_EVENT_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !(|ext_int) && !(tmr0_evt && tmr_wake_ok)
         && !(wdt_evt && wdt_wake_ok)) |=> !cpu_clk_en && !main_osc_en == !sleep_clks.main_osc); // R9

    AST_SLOW_ONLY_TIMER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        presc_slow |-> (kind == SLP_WAKE_TMR && !cpu_clk_en)); // R5

endmodule

// File: tb/lpm_seq_ctrl_tb.sv
module lpm_seq_ctrl_tb;

    localparam int LAT = 256;

    // Expected vector: {cfg_q[7:0], main, rc, presc, slow, tmr0, cpu, resume}
    localparam logic [6:0] V_RUN    = 7'b1110110;
    localparam logic [6:0] V_STOP   = 7'b0000000;
    localparam logic [6:0] V_RC     = 7'b0100000;
    localparam logic [6:0] V_TMR    = 7'b1011100;
    localparam logic [6:0] V_STAB   = 7'b1110100;
    localparam logic [6:0] V_RESUME = 7'b1110111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_bitop = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_q;
    logic [7:0] irq_hi = '0, irq_lo = '0;
    logic       stop_req = 1'b0;
    logic [1:0] ext_int = '0;
    logic       tmr0_evt = 1'b0, wdt_evt = 1'b0;
    logic       main_osc_en, rc_osc_en, presc_en, presc_slow, tmr0_en, cpu_clk_en, resume_pulse;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    logic [14:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    lpm_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bitop(cfg_bitop),
        .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .irq_hi(irq_hi), .irq_lo(irq_lo),
        .stop_req(stop_req), .ext_int(ext_int), .tmr0_evt(tmr0_evt), .wdt_evt(wdt_evt),
        .main_osc_en(main_osc_en), .rc_osc_en(rc_osc_en), .presc_en(presc_en),
        .presc_slow(presc_slow), .tmr0_en(tmr0_en), .cpu_clk_en(cpu_clk_en),
        .resume_pulse(resume_pulse)
    );

    // Monitor: compares the oldest expectation at each falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [14:0] e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {cfg_q, main_osc_en, rc_osc_en, presc_en, presc_slow, tmr0_en, cpu_clk_en, resume_pulse};
            total++;
            if (a !== e) begin
                bad++;
                $display("FAIL %s got=%h exp=%h", t, a, e);
            end
        end
    end

    task automatic push(input logic [7:0] c, input logic [6:0] v, input string t);
        exp_q.push_back({c, v});
        tag_q.push_back(t);
    endtask

    // One clock: inputs already set; expect values after the rising edge
    task automatic tick(input logic [7:0] c, input logic [6:0] v, input string t);
        @(posedge clk);
        #1;
        push(c, v, t);
        @(negedge clk);
        cfg_we = 1'b0; cfg_bitop = 1'b0; stop_req = 1'b0;
        ext_int = '0; tmr0_evt = 1'b0; wdt_evt = 1'b0;
    endtask

    task automatic write_cfg(input logic [7:0] d, input logic bitop, input logic [7:0] c_exp, input string t);
        cfg_we = 1'b1; cfg_bitop = bitop; cfg_wdata = d;
        tick(c_exp, V_RUN, t);
    endtask

    // Wake already applied on this tick; then the stabilization window and resume
    task automatic wake_and_resume(input logic [7:0] c, input string t);
        tick(c, V_STAB, t);
        for (int i = 1; i < LAT; i++) tick(c, V_STAB, t);
        tick(c, V_RESUME, t);
        tick(c, V_RUN, t);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        push(8'h00, V_RUN, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        tick(8'h00, V_RUN, "R1 after reset");

        // R2: bit access ignored, byte write taken
        write_cfg(8'h60, 1'b1, 8'h00, "R2 bitop ignored");
        write_cfg(8'h2E, 1'b0, 8'h2E, "R2 byte write");
        write_cfg(8'h0E, 1'b0, 8'h0E, "R2 byte write kind00");

        // R7: pending interrupts block entry
        irq_lo = 8'h01; stop_req = 1'b1;
        tick(8'h0E, V_RUN, "R7 irq_lo pending");
        irq_lo = 8'h00; irq_hi = 8'h80; stop_req = 1'b1;
        tick(8'h0E, V_RUN, "R7 irq_hi pending");
        irq_hi = 8'h00;

        // R3/R6: full stop
        stop_req = 1'b1;
        tick(8'h0E, V_STOP, "R3 R6 full stop");
        tmr0_evt = 1'b1;
        tick(8'h0E, V_STOP, "R9 tmr0 ignored in full stop");
        wdt_evt = 1'b1;
        tick(8'h0E, V_STOP, "R9 wdt ignored in full stop");
        ext_int = 2'b01;
        wake_and_resume(8'h0E, "R8 R10 INT0 wake");

        // R4: RC-watchdog sleep
        write_cfg(8'h20, 1'b0, 8'h20, "R2 kind01");
        stop_req = 1'b1;
        tick(8'h20, V_RC, "R4 R6 rc sleep");
        tmr0_evt = 1'b1;
        tick(8'h20, V_RC, "R9 tmr0 ignored in rc sleep");
        wdt_evt = 1'b1;
        wake_and_resume(8'h20, "R9 R10 wdt wake");

        // R5: timer sleep, both encodings of the low bit
        write_cfg(8'h60, 1'b0, 8'h60, "R2 kind11");
        stop_req = 1'b1;
        tick(8'h60, V_TMR, "R5 R6 timer sleep 11");
        wdt_evt = 1'b1;
        tick(8'h60, V_TMR, "R9 wdt ignored in timer sleep");
        tmr0_evt = 1'b1;
        wake_and_resume(8'h60, "R9 R10 tmr0 wake");

        write_cfg(8'h40, 1'b0, 8'h40, "R2 kind10");
        stop_req = 1'b1;
        tick(8'h40, V_TMR, "R5 timer sleep 10");
        ext_int = 2'b10;
        wake_and_resume(8'h40, "R8 INT1 wake");

        // R11: async reset while asleep
        write_cfg(8'h20, 1'b0, 8'h20, "R2 kind01 again");
        stop_req = 1'b1;
        tick(8'h20, V_RC, "R4 sleep before reset");
        #1;
        rst_n = 1'b0;
        #1;
        push(8'h00, V_RUN, "R11 async reset");
        @(negedge clk);
        rst_n = 1'b1;
        tick(8'h00, V_RUN, "R11 after reset");

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog got=%0d exp<=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule